// File: doc/BRIEF.md
# Reference-Count Frequency Meter

This block measures how fast a sensor clock runs compared with the reference clock. It counts sensor rising edges over a window of reference cycles whose length software chooses. At the end of each window it divides the edge count by the window length and scales the quotient by 2^24. A programmable offset is then subtracted, so that a small range of interest uses the full code. The result is a 24-bit code. The frequency follows from f_sensor = f_ref × divider × code / 2^24, where the offset is taken as zero.

The sensor input passes first through a selectable power-of-two divider in its own domain. It then crosses into the reference domain through a two-flop synchronizer and a rising-edge detector. Conversions run back to back without pause. Each finished conversion pulls an active-low ready flag low. The host reads the result one byte at a time with three read strobes, low byte first. The low-byte read freezes the whole code and the four error flags, so the middle and high bytes always belong to the same conversion.

Top module: `refcnt_freq_meter`

## Requirements
- R1: A conversion window lasts `ref_count` × 16 + 55 reference cycles. A `ref_count` below 2 acts as 2. Successive falls of `drdy_n` are exactly one window apart.
- R2: With E rising edges of the divided sensor clock in a window of W cycles, the code is floor(E × 2^24 / W) − `code_offset`.
- R3: `div_sel` divides the sensor clock before counting: 0 → 1, 1 → 2, 2 → 4, 3 → 8.
- R4: Over-range is raised when E × divider > W, which means the undivided sensor runs faster than the reference. The code then saturates to 0xFFFFFF.
- R5: Overflow is raised when 8 × E ≥ 3 × W, which means the divided stream is too close to the reference rate. The code then saturates to 0xFFFFFF.
- R6: Under-range is raised when floor(E × 2^24 / W) < `code_offset`. The code then clamps to 0, unless R4 or R5 saturates it.
- R7: Zero-count is raised when E = 0.
- R8: `rd_lo`, `rd_mid` and `rd_hi` load `rd_data` on the next clock edge with bits 7:0, 15:8 and 23:16. `rd_lo` also snapshots the code, and the middle and high reads return that snapshot even after newer conversions. With no strobe, `rd_data` holds its value.
- R9: `drdy_n` goes low when a conversion completes and goes high only through `rd_lo`.
- R10: The four error flags change only on `rd_lo`, and they then show the flags of the conversion whose code was captured.
- R11: After reset, `drdy_n` is 1 and `rd_data` and all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sens_clk | input | 1 | Raw sensor clock, asynchronous |
| ref_count | input | 16 | Window length setting |
| code_offset | input | 16 | Offset subtracted from the code |
| div_sel | input | 2 | Sensor divider select |
| rd_lo | input | 1 | Read strobe for bits 7:0, also snapshots the code |
| rd_mid | input | 1 | Read strobe for bits 15:8 |
| rd_hi | input | 1 | Read strobe for bits 23:16 |
| rd_data | output | 8 | Byte returned by the last strobe |
| drdy_n | output | 1 | Active-low data ready |
| err_zero | output | 1 | No sensor edges in window |
| err_over_range | output | 1 | Sensor faster than reference |
| err_under_range | output | 1 | Offset exceeded the code |
| err_overflow | output | 1 | Divided sensor too close to reference rate |

## Verification
The assertions assume that the host raises at most one read strobe per cycle. They also assume that strobes last one cycle, and the bench drives them one at a time that way. The design further relies on the window always being longer than the 45-cycle divide, which holds for any `ref_count` because the minimum window is 87 cycles. The bench places every sensor edge at a fractional-nanosecond phase that never coincides with a reference edge. Because the synchronizer phase is unknown, the bench accepts codes from edge counts within ±2 of nominal. The over-range and overflow cases use divided rates well clear of their thresholds.

// File: rtl/refcnt_freq_meter.sv
module refcnt_freq_meter #(
  parameter int CNT_W     = 16,
  parameter int RES_W     = 24,
  parameter int WIN_SHIFT = 4,
  parameter int WIN_ADD   = 55,
  parameter int MIN_CNT   = 2
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             sens_clk,
  input  logic [CNT_W-1:0] ref_count,
  input  logic [CNT_W-1:0] code_offset,
  input  logic [1:0]       div_sel,
  input  logic             rd_lo,
  input  logic             rd_mid,
  input  logic             rd_hi,
  output logic [7:0]       rd_data,
  output logic             drdy_n,
  output logic             err_zero,
  output logic             err_over_range,
  output logic             err_under_range,
  output logic             err_overflow
);
  localparam int WIN_W  = CNT_W + WIN_SHIFT + 1;
  localparam int NUM_W  = WIN_W + RES_W;
  localparam int STEP_W = $clog2(NUM_W);

  // sensor-domain divider
  logic [2:0] sdiv;
  logic       sens_pick;
  always_ff @(posedge sens_clk or negedge rst_n)
    if (!rst_n) sdiv <= '0;
    else        sdiv <= sdiv + 3'd1;

  always_comb
    case (div_sel)
      2'd0:    sens_pick = sens_clk;
      2'd1:    sens_pick = sdiv[0];
      2'd2:    sens_pick = sdiv[1];
      default: sens_pick = sdiv[2];
    endcase

  logic [2:0] sync_q;
  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], sens_pick};
  wire sens_rise = sync_q[1] & ~sync_q[2];

  // window
  wire [CNT_W-1:0] cnt_eff = (ref_count < CNT_W'(MIN_CNT)) ? CNT_W'(MIN_CNT) : ref_count;
  wire [WIN_W-1:0] win_len = (WIN_W'(cnt_eff) << WIN_SHIFT) + WIN_W'(WIN_ADD);

  logic [WIN_W-1:0] win_cnt, edge_cnt;
  wire              win_done = (win_cnt >= win_len - WIN_W'(1));
  wire [WIN_W-1:0]  edge_tot = edge_cnt + WIN_W'(sens_rise);

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      win_cnt  <= '0;
      edge_cnt <= '0;
    end else if (win_done) begin
      win_cnt  <= '0;
      edge_cnt <= '0;
    end else begin
      win_cnt  <= win_cnt + WIN_W'(1);
      edge_cnt <= edge_tot;
    end

  // serial divide of E*2^RES_W by W
  logic [WIN_W-1:0] cap_e, cap_win, rem;
  logic [1:0]       cap_div;
  logic [CNT_W-1:0] cap_off;
  logic [NUM_W-1:0] num;
  logic [RES_W:0]   quo;
  logic [STEP_W-1:0] step;
  logic             busy, fin;

  wire [WIN_W:0] trial = {rem, num[NUM_W-1]};
  wire           fits  = trial >= {1'b0, cap_win};

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      cap_e <= '0; cap_win <= '0; cap_div <= '0; cap_off <= '0;
      rem <= '0; num <= '0; quo <= '0; step <= '0;
      busy <= 1'b0; fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (win_done) begin
        cap_e   <= edge_tot;
        cap_win <= win_len;
        cap_div <= div_sel;
        cap_off <= code_offset;
        num     <= {edge_tot, RES_W'(0)};
        rem     <= '0;
        quo     <= '0;
        step    <= '0;
        busy    <= 1'b1;
      end else if (busy) begin
        rem  <= fits ? (trial[WIN_W-1:0] - cap_win) : trial[WIN_W-1:0];
        num  <= num << 1;
        quo  <= {quo[RES_W-1:0], fits};
        step <= step + STEP_W'(1);
        if (step == STEP_W'(NUM_W - 1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end

  // finalize
  wire [WIN_W+2:0] e_x8   = {cap_e, 3'b000};
  wire [WIN_W+2:0] w_x3   = ({3'b000, cap_win} << 1) + {3'b000, cap_win};
  wire [WIN_W+2:0] e_scl  = {3'b000, cap_e} << cap_div;
  wire             f_ovf  = e_x8 >= w_x3;
  wire             f_orng = e_scl > {3'b000, cap_win};
  wire             f_zero = (cap_e == '0);
  wire             f_undr = quo < (RES_W+1)'(cap_off);
  wire [RES_W-1:0] net    = quo[RES_W-1:0] - RES_W'(cap_off);
  wire [RES_W-1:0] new_res = (f_ovf | f_orng) ? '1 : (f_undr ? '0 : net);

  logic [RES_W-1:0] conv_res, snap;
  logic [3:0]       conv_err;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      conv_res <= '0;
      conv_err <= '0;
      drdy_n   <= 1'b1;
    end else if (fin) begin
      conv_res <= new_res;
      conv_err <= {f_zero, f_orng, f_undr, f_ovf};
      drdy_n   <= 1'b0;
    end else if (rd_lo) begin
      drdy_n   <= 1'b1;
    end

  // byte read port
  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      snap    <= '0;
      rd_data <= '0;
      {err_zero, err_over_range, err_under_range, err_overflow} <= '0;
    end else if (rd_lo) begin
      snap    <= conv_res;
      rd_data <= conv_res[7:0];
      {err_zero, err_over_range, err_under_range, err_overflow} <= conv_err;
    end else if (rd_mid) begin
      rd_data <= snap[15:8];
    end else if (rd_hi) begin
      rd_data <= snap[23:16];
    end
endmodule

module refcnt_freq_meter_chk (
  input logic       ref_clk,
  input logic       rst_n,
  input logic       rd_lo,
  input logic       rd_mid,
  input logic       rd_hi,
  input logic [7:0] rd_data,
  input logic       drdy_n,
  input logic       err_zero,
  input logic       err_over_range,
  input logic       err_under_range,
  input logic       err_overflow
);
  // R9
  drdy_release_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(drdy_n) |-> $past(rd_lo));

  // R10
  flags_hold_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !rd_lo |=> $stable({err_zero, err_over_range, err_under_range, err_overflow}));

  // R8
  data_hold_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !(rd_lo | rd_mid | rd_hi) |=> $stable(rd_data));

  // R4
  saturate_mid_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (err_over_range | err_overflow) && rd_mid && !rd_lo |=> rd_data == 8'hFF);

  // R6
  clamp_mid_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    err_under_range && !err_over_range && !err_overflow && rd_mid && !rd_lo
      |=> rd_data == 8'h00);
endmodule

bind refcnt_freq_meter refcnt_freq_meter_chk u_chk (
  .ref_clk(ref_clk), .rst_n(rst_n), .rd_lo(rd_lo), .rd_mid(rd_mid), .rd_hi(rd_hi),
  .rd_data(rd_data), .drdy_n(drdy_n), .err_zero(err_zero),
  .err_over_range(err_over_range), .err_under_range(err_under_range),
  .err_overflow(err_overflow)
);

// File: tb/refcnt_freq_meter_bench.sv
`timescale 1ns/1ps
module refcnt_freq_meter_bench;
  logic        clk = 1'b0, rst_n = 1'b0, sens_clk = 1'b0;
  logic [15:0] ref_count = 16'd20, code_offset = 16'd0;
  logic [1:0]  div_sel = 2'd0;
  logic        rd_lo = 1'b0, rd_mid = 1'b0, rd_hi = 1'b0;
  logic [7:0]  rd_data;
  logic        drdy_n, err_zero, err_over_range, err_under_range, err_overflow;

  int n_chk = 0, n_fail = 0;
  int unsigned cyc = 0;
  real sens_half = 10.0;
  bit  sens_on = 1'b0;

  refcnt_freq_meter u_refcnt_freq_meter (
    .ref_clk(clk), .rst_n(rst_n), .sens_clk(sens_clk), .ref_count(ref_count),
    .code_offset(code_offset), .div_sel(div_sel), .rd_lo(rd_lo), .rd_mid(rd_mid),
    .rd_hi(rd_hi), .rd_data(rd_data), .drdy_n(drdy_n), .err_zero(err_zero),
    .err_over_range(err_over_range), .err_under_range(err_under_range),
    .err_overflow(err_overflow));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    #1.3;
    forever begin
      if (sens_on) #(sens_half) sens_clk = ~sens_clk;
      else begin sens_clk = 1'b0; #5; end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp_v);
    end
  endtask

  task automatic chk_rng(input string req, input longint act, input longint lo, input longint hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h..0x%0h", req, act, lo, hi);
    end
  endtask

  task automatic strobe(input int which, output logic [7:0] b);
    @(negedge clk);
    rd_lo = (which == 0); rd_mid = (which == 1); rd_hi = (which == 2);
    @(negedge clk);
    rd_lo = 1'b0; rd_mid = 1'b0; rd_hi = 1'b0;
    b = rd_data;
  endtask

  task automatic read_all(output logic [23:0] r);
    logic [7:0] b0, b1, b2;
    strobe(0, b0); strobe(1, b1); strobe(2, b2);
    r = {b2, b1, b0};
  endtask

  task automatic wait_drdy();
    while (drdy_n !== 1'b0) @(negedge clk);
  endtask

  task automatic settle();
    logic [23:0] r;
    for (int i = 0; i < 3; i++) begin wait_drdy(); read_all(r); end
  endtask

  function automatic longint qcalc(longint e, longint w);
    return (e <<< 24) / w;
  endfunction

  function automatic logic [3:0] flags();
    return {err_zero, err_over_range, err_under_range, err_overflow};
  endfunction

  task automatic config_run(input real per, input logic [1:0] dv, input int rc, input int off);
    sens_on = (per > 0.0);
    if (per > 0.0) sens_half = per / 2.0;
    div_sel = dv; ref_count = 16'(rc); code_offset = 16'(off);
    settle();
  endtask

  task automatic t_measure(input string req, input real per, input logic [1:0] dv,
                           input int rc, input int off);
    logic [23:0] r;
    int w, elo, ehi, dn;
    real nom;
    config_run(per, dv, rc, off);
    w = rc * 16 + 55;
    dn = 1 << dv;
    nom = w * 5.0 / (per * dn);
    elo = int'($floor(nom)) - 2; if (elo < 0) elo = 0;
    ehi = int'($ceil(nom)) + 2;
    wait_drdy(); read_all(r);
    chk_rng(req, r, qcalc(elo, w) - off, qcalc(ehi, w) - off);
    chk(flags() == 4'b0000, {req, " flags clear"}, flags(), 0);
  endtask

  task automatic t_reset();
    chk(drdy_n == 1'b1, "R11 drdy_n", drdy_n, 1);
    chk(rd_data == 8'h00, "R11 rd_data", rd_data, 0);
    chk(flags() == 4'b0000, "R11 flags", flags(), 0);
  endtask

  task automatic t_window(input int rc, input int exp_len);
    logic [7:0] b;
    int unsigned t1, t2;
    config_run(20.0, 2'd0, rc, 0);
    wait_drdy(); t1 = cyc;
    strobe(0, b);
    wait_drdy(); t2 = cyc;
    chk(t2 - t1 == exp_len, "R1 window length", t2 - t1, exp_len);
    strobe(0, b);
  endtask

  task automatic t_saturate(input string req, input real per, input logic [1:0] dv,
                            input logic [3:0] exp_f);
    logic [23:0] r;
    config_run(per, dv, 20, 0);
    wait_drdy(); read_all(r);
    chk(r == 24'hFFFFFF, {req, " saturated code"}, r, 24'hFFFFFF);
    chk(flags() == exp_f, {req, " flags"}, flags(), exp_f);
  endtask

  task automatic t_under();
    logic [23:0] r;
    config_run(250.0, 2'd3, 200, 16'hFFFF);
    wait_drdy(); read_all(r);
    chk(r == 24'h0, "R6 clamp to zero", r, 0);
    chk(flags() == 4'b0010, "R6 under-range flag", flags(), 4'b0010);
  endtask

  task automatic t_zero();
    logic [23:0] r;
    config_run(0.0, 2'd0, 20, 0);
    wait_drdy(); read_all(r);
    chk(r == 24'h0, "R7 zero code", r, 0);
    chk(flags() == 4'b1000, "R7 zero-count flag", flags(), 4'b1000);
  endtask

  task automatic t_coherent();
    logic [7:0] b0, b1, b2;
    longint lo, hi;
    config_run(20.0, 2'd0, 20, 0);
    wait_drdy();
    strobe(0, b0);
    chk(drdy_n == 1'b1, "R9 drdy_n released by low read", drdy_n, 1);
    sens_half = 2.0; div_sel = 2'd3;
    repeat (3 * 375 + 200) @(negedge clk);
    chk(drdy_n == 1'b0, "R9 drdy_n low on completion", drdy_n, 0);
    chk(err_over_range == 1'b0, "R10 flags wait for low read", err_over_range, 0);
    strobe(1, b1); strobe(2, b2);
    lo = qcalc(91, 375); hi = qcalc(96, 375);
    chk_rng("R8 coherent snapshot", {b2, b1, b0}, lo, hi);
    strobe(0, b0);
    chk(err_over_range == 1'b1, "R10 flags update on low read", err_over_range, 1);
    chk(b0 == 8'hFF, "R8 low byte of new code", b0, 8'hFF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    sens_on = 1'b1;
    t_window(2, 87);
    t_window(0, 87);
    t_window(10, 215);
    t_measure("R2 ratio div1", 20.0, 2'd0, 20, 0);
    t_measure("R3 divide by 2", 10.0, 2'd1, 20, 0);
    t_measure("R3 divide by 4", 6.0, 2'd2, 20, 0);
    t_measure("R2 offset subtract", 20.0, 2'd0, 20, 16'h1000);
    t_saturate("R4 over-range", 4.0, 2'd3, 4'b0100);
    t_saturate("R5 overflow", 10.0, 2'd0, 4'b0001);
    t_under();
    t_zero();
    t_coherent();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule